// File: doc/BRIEF.md
# Multi-Chip Sector Erase Sequencer

This block turns one erase request, given as a byte start address and a byte length over a linear space, into a series of single-sector erase commands. The linear space is built from several chips placed end to end. Each chip is an interleaved group of identical devices, so one chip covers the size of one device times the interleave factor. Every sector has the same size, 128 KiB by default.

A request is checked in the cycle it arrives. A start address or length that is not a whole number of sectors, or a range that runs past the end of the space, is refused with a one-cycle invalid-argument pulse. A valid request sets the starting chip and the offset inside that chip. The block then offers one sector command at a time to a downstream erase engine. It holds the command until the engine accepts it, then waits for the engine's completion strobe. After that it steps to the next sector and moves on to the next chip when the current one is used up. An error from the engine ends the walk at once. A clean end of the range gives a one-cycle completion pulse.

Top module: `erase_range_walker`

## Requirements
- R1: A request whose start address has any of its low SECTOR_SHIFT bits set gives `opBadArg` high for exactly the cycle after acceptance, and no sector command follows.
- R2: A request whose length has any of its low SECTOR_SHIFT bits set is refused the same way as in R1. This applies to a zero length too when the address is misaligned.
- R3: A request with start plus length greater than NUM_CHIPS × INTERLEAVE × 2^DEV_SHIFT is refused as in R1. A range that ends exactly at that total is accepted.
- R4: The first command of a valid request carries chip index (addr >> DEV_SHIFT) / INTERLEAVE and offset addr − chip × INTERLEAVE × 2^DEV_SHIFT.
- R5: A valid request of length L issues exactly L / 2^SECTOR_SHIFT commands. Within one chip, each offset is the previous one plus 2^SECTOR_SHIFT.
- R6: When the next offset would equal the chip span INTERLEAVE × 2^DEV_SHIFT, the next command carries offset 0 and the chip index plus one. `secChip` never reaches NUM_CHIPS.
- R7: `secValid` stays high with `secChip` and `secOffset` unchanged until `secReady` is seen. No new command is offered between an acceptance and the matching `secDone`.
- R8: A `secDone` with `secErr` high gives `opFail` high for one cycle after it. `busy` drops in that cycle, and no further command of that request is offered.
- R9: The cycle after the `secDone` (with `secErr` low) of the last sector, `opDone` is high for one cycle and `busy` is low. At most one of `opDone`, `opBadArg` and `opFail` is high in any cycle.
- R10: A valid request of zero length gives `opDone` in the cycle after acceptance and issues no command.
- R11: `reqValid` is ignored while `busy` is high. The walk in progress is not changed, and no extra command or status pulse follows.
- R12: After reset `busy`, `secValid`, `opDone`, `opBadArg` and `opFail` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Erase request strobe, taken when `busy` is low |
| reqAddr | input | ADDR_W | Byte start address of the range |
| reqLen | input | ADDR_W | Byte length of the range |
| busy | output | 1 | A walk is in progress |
| secValid | output | 1 | A sector command is offered |
| secReady | input | 1 | The engine accepts the offered command |
| secChip | output | CHIP_W | Chip index of the offered command |
| secOffset | output | ADDR_W | Byte offset of the sector inside its chip |
| secDone | input | 1 | The engine has finished the accepted sector |
| secErr | input | 1 | Qualifies `secDone`: the sector failed |
| opDone | output | 1 | One-cycle pulse: whole range erased |
| opBadArg | output | 1 | One-cycle pulse: request refused |
| opFail | output | 1 | One-cycle pulse: walk aborted by an engine error |

## Verification
The hardest situation to reach is a walk that crosses a chip boundary while the engine takes its time. In that case the rollover to offset 0 and the next chip must happen exactly once, and the command must stay steady over stalled cycles. The bench reaches it with an engine model that has adjustable accept and completion delays. Requests start a few sectors below a chip's end, and one request covers the whole space so that the last step lands on the final chip's end. An error is injected on a chosen sector number, and a second request is sent during a long walk, to show that both the abort and the busy guard leave no stray commands.

// File: rtl/erw_pkg.sv
package erw_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_ISSUE = 2'd1,
    WALK_WAIT  = 2'd2
  } walkState_t;

  typedef struct packed {
    logic load;   // capture start chip / offset / length
    logic step;   // one sector finished cleanly: advance
  } walkCtl_t;
endpackage

// File: rtl/erw_argcheck.sv
module erw_argcheck #(
  parameter int ADDR_W       = 32,
  parameter int DEV_SHIFT    = 19,
  parameter int INTERLEAVE   = 2,
  parameter int NUM_CHIPS    = 3,
  parameter int SECTOR_SHIFT = 17,
  parameter int CHIP_W       = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] len,
  output logic              argBad,
  output logic              zeroLen,
  output logic [CHIP_W-1:0] startChip,
  output logic [ADDR_W-1:0] startOff
);
  localparam longint CHIP_SPAN = (longint'(1) << DEV_SHIFT) * INTERLEAVE;
  localparam longint TOTAL     = CHIP_SPAN * NUM_CHIPS;
  localparam logic [ADDR_W:0]   TOTAL_V = (ADDR_W+1)'(TOTAL);
  localparam logic [ADDR_W-1:0] SPAN_V  = ADDR_W'(CHIP_SPAN);
  localparam logic [ADDR_W-1:0] ILV_V   = ADDR_W'(INTERLEAVE);

  logic [ADDR_W:0]   rangeEnd;
  logic [ADDR_W-1:0] chipIdx;
  logic              addrMis;
  logic              lenMis;

  always_comb begin
    addrMis  = |addr[SECTOR_SHIFT-1:0];
    lenMis   = |len[SECTOR_SHIFT-1:0];
    rangeEnd = {1'b0, addr} + {1'b0, len};
    argBad   = addrMis || lenMis || (rangeEnd > TOTAL_V);
    zeroLen  = (len == '0);
    chipIdx  = (addr >> DEV_SHIFT) / ILV_V;
    startChip = CHIP_W'(chipIdx);
    startOff  = addr - chipIdx * SPAN_V;
  end
endmodule

// File: rtl/erw_datapath.sv
module erw_datapath
  import erw_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DEV_SHIFT    = 19,
  parameter int INTERLEAVE   = 2,
  parameter int NUM_CHIPS    = 3,
  parameter int SECTOR_SHIFT = 17,
  parameter int CHIP_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] reqLen,
  output logic              argBad,
  output logic              zeroLen,
  output logic [CHIP_W-1:0] curChip,
  output logic [ADDR_W-1:0] curOff,
  output logic              lastSector,
  output logic              lastChipWrap
);
  localparam longint CHIP_SPAN = (longint'(1) << DEV_SHIFT) * INTERLEAVE;
  localparam logic [ADDR_W-1:0] SECTOR_V  = ADDR_W'(longint'(1) << SECTOR_SHIFT);
  localparam logic [ADDR_W-1:0] WRAP_AT   = ADDR_W'(CHIP_SPAN - (longint'(1) << SECTOR_SHIFT));
  localparam logic [CHIP_W-1:0] FINAL_CHIP = CHIP_W'(NUM_CHIPS - 1);

  logic [CHIP_W-1:0] startChip;
  logic [ADDR_W-1:0] startOff;
  logic [ADDR_W-1:0] remLen;
  logic              wrapNow;

  erw_argcheck #(
    .ADDR_W(ADDR_W), .DEV_SHIFT(DEV_SHIFT), .INTERLEAVE(INTERLEAVE),
    .NUM_CHIPS(NUM_CHIPS), .SECTOR_SHIFT(SECTOR_SHIFT), .CHIP_W(CHIP_W)
  ) u_argcheck (
    .addr(reqAddr), .len(reqLen), .argBad(argBad), .zeroLen(zeroLen),
    .startChip(startChip), .startOff(startOff)
  );

  always_comb begin
    wrapNow      = (curOff == WRAP_AT);
    lastSector   = (remLen == SECTOR_V);
    lastChipWrap = wrapNow && (curChip == FINAL_CHIP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curChip <= '0;
      curOff  <= '0;
      remLen  <= '0;
    end else if (ctl.load) begin
      curChip <= startChip;
      curOff  <= startOff;
      remLen  <= reqLen;
    end else if (ctl.step) begin
      remLen <= remLen - SECTOR_V;
      if (wrapNow) begin
        curOff  <= '0;
        curChip <= curChip + 1'b1;
      end else begin
        curOff <= curOff + SECTOR_V;
      end
    end
  end
endmodule

// File: rtl/erw_control.sv
module erw_control
  import erw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     argBad,
  input  logic     zeroLen,
  input  logic     lastSector,
  input  logic     lastChipWrap,
  input  logic     secReady,
  input  logic     secDone,
  input  logic     secErr,
  output walkCtl_t ctl,
  output logic     busy,
  output logic     secValid,
  output logic     opDone,
  output logic     opBadArg,
  output logic     opFail
);
  walkState_t state, stateNext;
  logic       takeReq;
  logic       sectorOk;
  logic       walkEnds;

  always_comb begin
    takeReq  = (state == WALK_IDLE) && reqValid;
    sectorOk = (state == WALK_WAIT) && secDone && !secErr;
    walkEnds = sectorOk && (lastSector || lastChipWrap);
    ctl.load = takeReq && !argBad && !zeroLen;
    ctl.step = sectorOk;
    stateNext = state;
    unique case (state)
      WALK_IDLE:  if (ctl.load) stateNext = WALK_ISSUE;
      WALK_ISSUE: if (secReady) stateNext = WALK_WAIT;
      WALK_WAIT: begin
        if (secDone) stateNext = (secErr || walkEnds) ? WALK_IDLE : WALK_ISSUE;
      end
      default:    stateNext = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= WALK_IDLE;
      opDone   <= 1'b0;
      opBadArg <= 1'b0;
      opFail   <= 1'b0;
    end else begin
      state    <= stateNext;
      opDone   <= walkEnds || (takeReq && !argBad && zeroLen);
      opBadArg <= takeReq && argBad;
      opFail   <= (state == WALK_WAIT) && secDone && secErr;
    end
  end

  assign busy     = (state != WALK_IDLE);
  assign secValid = (state == WALK_ISSUE);
endmodule

// File: rtl/erase_range_walker.sv
module erase_range_walker
  import erw_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DEV_SHIFT    = 19,
  parameter int INTERLEAVE   = 2,
  parameter int NUM_CHIPS    = 3,
  parameter int SECTOR_SHIFT = 17,
  localparam int CHIP_W      = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] reqLen,
  output logic              busy,
  output logic              secValid,
  input  logic              secReady,
  output logic [CHIP_W-1:0] secChip,
  output logic [ADDR_W-1:0] secOffset,
  input  logic              secDone,
  input  logic              secErr,
  output logic              opDone,
  output logic              opBadArg,
  output logic              opFail
);
  walkCtl_t ctl;
  logic     argBad, zeroLen, lastSector, lastChipWrap;

  erw_datapath #(
    .ADDR_W(ADDR_W), .DEV_SHIFT(DEV_SHIFT), .INTERLEAVE(INTERLEAVE),
    .NUM_CHIPS(NUM_CHIPS), .SECTOR_SHIFT(SECTOR_SHIFT), .CHIP_W(CHIP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqLen(reqLen),
    .argBad(argBad), .zeroLen(zeroLen), .curChip(secChip), .curOff(secOffset),
    .lastSector(lastSector), .lastChipWrap(lastChipWrap)
  );

  erw_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .argBad(argBad),
    .zeroLen(zeroLen), .lastSector(lastSector), .lastChipWrap(lastChipWrap),
    .secReady(secReady), .secDone(secDone), .secErr(secErr), .ctl(ctl),
    .busy(busy), .secValid(secValid), .opDone(opDone), .opBadArg(opBadArg),
    .opFail(opFail)
  );
endmodule

// File: rtl/erw_checker.sv
module erw_checker #(
  parameter int ADDR_W       = 32,
  parameter int DEV_SHIFT    = 19,
  parameter int INTERLEAVE   = 2,
  parameter int NUM_CHIPS    = 3,
  parameter int SECTOR_SHIFT = 17,
  parameter int CHIP_W       = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              secValid,
  input logic              secReady,
  input logic [CHIP_W-1:0] secChip,
  input logic [ADDR_W-1:0] secOffset,
  input logic              secDone,
  input logic              opDone,
  input logic              opBadArg,
  input logic              opFail
);
  localparam longint SPAN = (longint'(1) << DEV_SHIFT) * INTERLEAVE;
  logic pending;

  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else if (secValid && secReady) pending <= 1'b1;
    else if (secDone) pending <= 1'b0;
  end

  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rstN)
    secValid && !secReady |=> secValid && $stable(secChip) && $stable(secOffset)); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    secValid |-> !pending); // R7
  AST_CHIP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    secValid |-> (int'(secChip) < NUM_CHIPS)); // R6
  AST_SECTOR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    secValid |-> (secOffset[SECTOR_SHIFT-1:0] == '0) && (longint'(secOffset) < SPAN)); // R5
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opDone, opBadArg, opFail})); // R9
  AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    opFail |-> !busy && !secValid); // R8
  AST_BADARG_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    opBadArg |-> !busy && !secValid); // R1
endmodule

bind erase_range_walker erw_checker #(
  .ADDR_W(ADDR_W), .DEV_SHIFT(DEV_SHIFT), .INTERLEAVE(INTERLEAVE),
  .NUM_CHIPS(NUM_CHIPS), .SECTOR_SHIFT(SECTOR_SHIFT), .CHIP_W(CHIP_W)
) u_erw_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .secValid(secValid), .secReady(secReady),
  .secChip(secChip), .secOffset(secOffset), .secDone(secDone), .opDone(opDone),
  .opBadArg(opBadArg), .opFail(opFail)
);

// File: tb/tb_erase_range_walker.sv
`timescale 1ns/1ps
module tb_erase_range_walker;
  localparam int     ADDR_W = 32;
  localparam longint SEC    = 64'h20000;
  localparam longint SPAN   = 64'h100000;  // (1<<19) * 2
  localparam longint TOTAL  = SPAN * 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0, reqLen = '0;
  logic secReady = 1'b0, secDone = 1'b0, secErr = 1'b0;
  logic busy, secValid, opDone, opBadArg, opFail;
  logic [1:0] secChip;
  logic [ADDR_W-1:0] secOffset;

  always #4 clk = ~clk;

  erase_range_walker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqLen(reqLen),
    .busy(busy), .secValid(secValid), .secReady(secReady), .secChip(secChip),
    .secOffset(secOffset), .secDone(secDone), .secErr(secErr), .opDone(opDone),
    .opBadArg(opBadArg), .opFail(opFail)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int stallCyc = 0, workCyc = 1;
  int cmdCount = 0, errAt = -1;
  string ctxTag = "R12";

  int     expChipQ[$];
  longint expOffQ[$];
  string  expCmdTag[$];
  int     expOutQ[$];   // 0 done, 1 bad argument, 2 fail
  string  expOutTag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // downstream engine model
  initial begin
    forever begin
      @(posedge clk); #1;
      if (secValid) begin
        for (int s = 0; s < stallCyc; s++) begin @(posedge clk); #1; end
        secReady = 1'b1;
        @(posedge clk); #1;
        secReady = 1'b0;
        for (int w = 0; w < workCyc; w++) begin @(posedge clk); #1; end
        secErr  = (cmdCount == errAt);
        secDone = 1'b1;
        cmdCount++;
        @(posedge clk); #1;
        secDone = 1'b0;
        secErr  = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  bit outstanding = 0;
  bit prevStall = 0;
  logic [1:0] heldChip;
  logic [ADDR_W-1:0] heldOff;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall)
        check(secValid && secChip == heldChip && secOffset == heldOff, "R7",
              "command changed while stalled", {secChip, secOffset}, {heldChip, heldOff});
      prevStall = secValid && !secReady;
      heldChip = secChip;
      heldOff  = secOffset;
      if (secValid && outstanding)
        check(1'b0, "R7", "command offered before completion", 1, 0);
      if (secValid && secReady) begin
        if (expChipQ.size() == 0) begin
          check(1'b0, ctxTag, "unexpected command", {secChip, secOffset}, 0);
        end else begin
          automatic int     ec = expChipQ.pop_front();
          automatic longint eo = expOffQ.pop_front();
          automatic string  et = expCmdTag.pop_front();
          check(secChip == ec && longint'(secOffset) == eo, et, "command chip/offset",
                {secChip, secOffset}, (longint'(ec) << 32) | eo);
        end
        outstanding = 1;
      end
      if (secDone) outstanding = 0;
      if (opDone || opBadArg || opFail) begin
        automatic int act = opDone ? 0 : (opBadArg ? 1 : 2);
        if (expOutQ.size() == 0) begin
          check(1'b0, ctxTag, "unexpected status pulse", act, -1);
        end else begin
          automatic int    eo2 = expOutQ.pop_front();
          automatic string et2 = expOutTag.pop_front();
          check(act == eo2 && !busy, et2, "status outcome", act, eo2);
        end
      end
    end
  end

  // driver: computes the expected sector list and outcome, then sends the request
  task automatic doReq(input longint addr, input longint len, input int errK,
                       input string tag, input bit intrude);
    automatic bit bad = (addr % SEC != 0) || (len % SEC != 0) || (addr + len > TOTAL);
    ctxTag = tag;
    while (busy) @(posedge clk);
    if (bad) begin
      expOutQ.push_back(1); expOutTag.push_back(tag);
    end else if (len == 0) begin
      expOutQ.push_back(0); expOutTag.push_back(tag);
    end else begin
      automatic int     n    = int'(len / SEC);
      automatic int     chip = int'((addr / (SPAN / 2)) / 2);
      automatic longint off  = addr - chip * SPAN;
      automatic int     last = (errK >= 0 && errK < n) ? errK : n - 1;
      for (int k = 0; k <= last; k++) begin
        expChipQ.push_back(chip); expOffQ.push_back(off);
        expCmdTag.push_back(k == 0 ? "R4" : tag);
        off += SEC;
        if (off == SPAN) begin off = 0; chip++; end
      end
      expOutQ.push_back((errK >= 0 && errK < n) ? 2 : 0);
      expOutTag.push_back(tag);
    end
    errAt = (errK >= 0) ? cmdCount + errK : -1;
    @(posedge clk); #1;
    reqAddr = ADDR_W'(addr); reqLen = ADDR_W'(len); reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    if (intrude) begin
      repeat (3) @(posedge clk);
      #1;
      check(busy == 1'b1, "R11", "busy during walk", busy, 1);
      reqAddr = '0; reqLen = ADDR_W'(SEC); reqValid = 1'b1;
      @(posedge clk); #1;
      reqValid = 1'b0;
    end
    while (expOutQ.size() > 0) @(negedge clk);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(expChipQ.size() == 0, tag, "missing commands", expChipQ.size(), 0);
    check(!busy && !secValid, tag, "idle after outcome", {busy, secValid}, 0);
    expChipQ.delete(); expOffQ.delete(); expCmdTag.delete();
    errAt = -1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!busy && !secValid, "R12", "busy/secValid after reset", {busy, secValid}, 0);
    check(!opDone && !opBadArg && !opFail, "R12", "status after reset",
          {opDone, opBadArg, opFail}, 0);

    stallCyc = 0; workCyc = 1;
    doReq(0, 2 * SEC, -1, "R5", 0);                     // two sectors in chip 0
    stallCyc = 2; workCyc = 3;
    doReq(SPAN + 5 * SEC, 4 * SEC, -1, "R6", 0);        // chip 1 -> chip 2 rollover
    doReq(SEC + 64'h100, SEC, -1, "R1", 0);             // misaligned start
    doReq(2 * SEC, SEC + 64'h8, -1, "R2", 0);           // misaligned length
    doReq(64'h40, 0, -1, "R2", 0);                      // zero length, misaligned start
    doReq(TOTAL - SEC, 2 * SEC, -1, "R3", 0);           // runs past the end
    stallCyc = 0; workCyc = 2;
    doReq(TOTAL - 2 * SEC, 2 * SEC, -1, "R3", 0);       // ends exactly at the end
    doReq(3 * SEC, 0, -1, "R10", 0);                    // zero length
    stallCyc = 1; workCyc = 2;
    doReq(6 * SEC, 4 * SEC, 1, "R8", 0);                // error on second sector
    stallCyc = 3; workCyc = 4;
    doReq(SPAN - SEC, 5 * SEC, -1, "R11", 1);           // request while busy
    stallCyc = 0; workCyc = 1;
    doReq(0, TOTAL, -1, "R9", 0);                       // whole space, ends on final chip

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired during %s", ctxTag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule